// File: doc/BRIEF.md
# Timer Dual Trigger Output Selector

This block drives the two trigger outputs of an advanced timer: a primary trigger and a secondary trigger. Each output has its own mode field in one control register. The mode field picks which internal timer condition appears on that output. The conditions are:

- a counter reset pulse,
- the counter enable level,
- the update event,
- the capture/compare event,
- one of the compare reference levels.

The secondary output has eight further modes. These pass the fifth and sixth reference levels through, or build one-cycle pulses from chosen edges of references four, five and six, joined by OR.

The counter, the compare channels and the prescaler are outside this block and arrive as inputs. Both trigger outputs are registered, so each output shows, one clock later, the condition it sampled at a clock edge.

A parameter can remove the secondary output. When it is removed, the secondary mode field ignores writes and reads back as zero. Software can therefore detect the feature by writing the field and reading it back.

Top module: `tmr_trig_sel`

## Requirements
- R1: While reset is asserted, and after it is released, the control register reads 0 and both trigger outputs are low.
- R2: A write loads the primary mode from control bits 6:4 and the secondary mode from bits 23:20. Every other bit reads as 0. Without a write, the register holds its value.
- R3: Codes 0 to 3 behave the same on both outputs, one cycle after the inputs are sampled: code 0 gives a one-cycle pulse on a counter reset, code 1 follows the counter enable level, code 2 outputs the update event OR the forced update strobe, and code 3 outputs the compare event.
- R4: Codes 4, 5, 6 and 7 output the levels of references one, two, three and four (oc_ref_i bits 0 to 3), delayed by one cycle.
- R5: On the secondary output, code 8 passes the reference five level (bit 4) and code 9 passes the reference six level (bit 5).
- R6: Code 10 pulses on every change of reference four. Code 11 pulses on every change of reference six.
- R7: Code 12 pulses on a rise of reference four or a rise of reference six. Code 13 pulses on a rise of reference four or a fall of reference six.
- R8: Code 14 pulses on a rise of reference five or a rise of reference six. Code 15 pulses on a rise of reference five or a fall of reference six.
- R9: Each edge pulse is high for exactly one cycle: the cycle after the edge is sampled. A reference that holds steady gives no further pulse.
- R10: With HAS_SEC=0, writes to bits 23:20 are ignored, those bits read as 0, and the secondary output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| ctrl_rdata_o | output | 32 | Control register read data |
| cnt_rst_i | input | 1 | Counter reset event |
| cnt_en_i | input | 1 | Counter enable level |
| upd_evt_i | input | 1 | Counter update event |
| upd_force_i | input | 1 | Software update strobe |
| cmp_evt_i | input | 1 | Capture/compare event |
| oc_ref_i | input | 6 | Compare reference levels, bit 0 = reference one |
| trg_pri_o | output | 1 | Primary trigger output |
| trg_sec_o | output | 1 | Secondary trigger output |

## Verification
The bench targets three kinds of error in the pulse modes:

- **Swapped polarity.** Codes 13 and 15 take a falling edge on reference six while codes 12 and 14 take a rising one. A design that swapped them would fire on the wrong transition, or stay silent on the right one.
- **Wrong reference.** Vectors change only a reference that the selected code ignores. This exposes a design that joins the wrong bits into the OR.
- **Held pulse.** A reference is held steady after its edge. A design that outputs the edge condition as a level, instead of a one-cycle pulse, would hold the output high.

The bench also checks four more things:

- The primary field decodes only codes 0 to 7.
- A build without the secondary output reads its field as zero and keeps that output low while the same stimulus runs.
- The register keeps its value across cycles with no write.
- An asynchronous reset clears the register and both outputs at once.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;
  localparam int CTRL_W  = 32;
  localparam int NUM_REF = 6;
  localparam int PRI_W   = 3;
  localparam int SEC_W   = 4;
  localparam int PRI_LSB = 4;
  localparam int SEC_LSB = 20;
  localparam int EDG_N   = 3;   // references four to six carry edge modes
  localparam int EDG_LSB = 3;

  typedef enum logic [SEC_W-1:0] {
    M_RST  = 4'd0,
    M_EN   = 4'd1,
    M_UPD  = 4'd2,
    M_CMP  = 4'd3,
    M_OC1  = 4'd4,
    M_OC2  = 4'd5,
    M_OC3  = 4'd6,
    M_OC4  = 4'd7,
    M_OC5  = 4'd8,
    M_OC6  = 4'd9,
    M_P4   = 4'd10,
    M_P6   = 4'd11,
    M_R4R6 = 4'd12,
    M_R4F6 = 4'd13,
    M_R5R6 = 4'd14,
    M_R5F6 = 4'd15
  } mode_e;

  typedef struct packed {
    logic cnt_rst;
    logic cnt_en;
    logic upd;
    logic cmp;
  } evt_t;
endpackage

// File: rtl/tmr_trig_regs.sv
module tmr_trig_regs
  import tmr_trig_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic [PRI_W-1:0]  pri_mode_o,
  output logic [SEC_W-1:0]  sec_mode_o
);
  logic [PRI_W-1:0] pri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pri_q <= '0;
    else if (we_i) pri_q <= wdata_i[PRI_LSB +: PRI_W];
  end

  generate
    if (HAS_SEC) begin : g_sec
      logic [SEC_W-1:0] sec_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   sec_q <= '0;
        else if (we_i) sec_q <= wdata_i[SEC_LSB +: SEC_W];
      end
      assign sec_mode_o = sec_q;
    end else begin : g_nosec
      assign sec_mode_o = '0;  // absent field reads zero for detection
    end
  endgenerate

  assign pri_mode_o = pri_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[PRI_LSB +: PRI_W] = pri_q;
    rdata_o[SEC_LSB +: SEC_W] = sec_mode_o;
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[CTRL_W-1:SEC_LSB+SEC_W],
                          wdata_i[SEC_LSB-1:PRI_LSB+PRI_W],
                          wdata_i[PRI_LSB-1:0]};

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
  a_r2_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[PRI_LSB +: PRI_W] == $past(wdata_i[PRI_LSB +: PRI_W]));
endmodule

// File: rtl/tmr_trig_edge.sv
module tmr_trig_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ref_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= ref_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise_o[i] =  ref_i[i] & ~prev_q[i];
    assign fall_o[i] = ~ref_i[i] &  prev_q[i];
  end

  a_r9_edge_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux
  import tmr_trig_pkg::*;
#(
  parameter int MODE_W = SEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_i,
  input  evt_t               evt_i,
  input  logic [NUM_REF-1:0] lvl_i,
  input  logic [EDG_N-1:0]   rise_i,  // bit 0 = ref four .. bit 2 = ref six
  input  logic [EDG_N-1:0]   fall_i,
  output logic               trg_o
);
  logic [SEC_W-1:0] mode_w;
  logic             sel;

  assign mode_w = SEC_W'(mode_i);

  always_comb begin
    unique case (mode_e'(mode_w))
      M_RST:   sel = evt_i.cnt_rst;
      M_EN:    sel = evt_i.cnt_en;
      M_UPD:   sel = evt_i.upd;
      M_CMP:   sel = evt_i.cmp;
      M_OC1:   sel = lvl_i[0];
      M_OC2:   sel = lvl_i[1];
      M_OC3:   sel = lvl_i[2];
      M_OC4:   sel = lvl_i[3];
      M_OC5:   sel = lvl_i[4];
      M_OC6:   sel = lvl_i[5];
      M_P4:    sel = rise_i[0] | fall_i[0];
      M_P6:    sel = rise_i[2] | fall_i[2];
      M_R4R6:  sel = rise_i[0] | rise_i[2];
      M_R4F6:  sel = rise_i[0] | fall_i[2];
      M_R5R6:  sel = rise_i[1] | rise_i[2];
      M_R5F6:  sel = rise_i[1] | fall_i[2];
      default: sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trg_o <= 1'b0;
    else         trg_o <= sel;
  end

  a_r9_quiet_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == M_P4 && !rise_i[0] && !fall_i[0]) |=> !trg_o);
  a_r3_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == M_EN) |=> trg_o == $past(evt_i.cnt_en));
endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
  import tmr_trig_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  output logic [31:0] ctrl_rdata_o,
  input  logic        cnt_rst_i,
  input  logic        cnt_en_i,
  input  logic        upd_evt_i,
  input  logic        upd_force_i,
  input  logic        cmp_evt_i,
  input  logic [5:0]  oc_ref_i,
  output logic        trg_pri_o,
  output logic        trg_sec_o
);
  logic [PRI_W-1:0] pri_mode;
  logic [SEC_W-1:0] sec_mode;
  evt_t             evt;

  assign evt = '{cnt_rst: cnt_rst_i, cnt_en: cnt_en_i,
                 upd: upd_evt_i | upd_force_i, cmp: cmp_evt_i};

  tmr_trig_regs #(.HAS_SEC(HAS_SEC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .rdata_o    (ctrl_rdata_o),
    .pri_mode_o (pri_mode),
    .sec_mode_o (sec_mode)
  );

  tmr_trig_mux #(.MODE_W(PRI_W)) u_pri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (pri_mode),
    .evt_i  (evt),
    .lvl_i  (oc_ref_i),
    .rise_i ('0),
    .fall_i ('0),
    .trg_o  (trg_pri_o)
  );

  generate
    if (HAS_SEC) begin : g_sec
      logic [EDG_N-1:0] rise, fall;
      tmr_trig_edge #(.N(EDG_N)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (oc_ref_i[EDG_LSB +: EDG_N]),
        .rise_o (rise),
        .fall_o (fall)
      );
      tmr_trig_mux #(.MODE_W(SEC_W)) u_sec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (sec_mode),
        .evt_i  (evt),
        .lvl_i  (oc_ref_i),
        .rise_i (rise),
        .fall_i (fall),
        .trg_o  (trg_sec_o)
      );
    end else begin : g_nosec
      logic unused_sec;
      assign unused_sec = ^sec_mode;
      assign trg_sec_o  = 1'b0;
    end
  endgenerate

  a_r3_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_mode == PRI_W'(M_UPD)) |=> trg_pri_o == $past(upd_evt_i | upd_force_i));
  a_r4_level_oc1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_mode == PRI_W'(M_OC1)) |=> trg_pri_o == $past(oc_ref_i[0]));
endmodule

// File: tb/sim_tmr_trig_sel.sv
module sim_tmr_trig_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        c_rst = 0, c_en = 0, upd = 0, sw = 0, cmp = 0;
  logic [5:0]  oc = '0;
  logic        p0, s0, p1, s1;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  tmr_trig_sel #(.HAS_SEC(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata0), .cnt_rst_i(c_rst), .cnt_en_i(c_en),
    .upd_evt_i(upd), .upd_force_i(sw), .cmp_evt_i(cmp), .oc_ref_i(oc),
    .trg_pri_o(p0), .trg_sec_o(s0));

  tmr_trig_sel #(.HAS_SEC(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata1), .cnt_rst_i(c_rst), .cnt_en_i(c_en),
    .upd_evt_i(upd), .upd_force_i(sw), .cmp_evt_i(cmp), .oc_ref_i(oc),
    .trg_pri_o(p1), .trg_sec_o(s1));

  // {pri[2:0], sec[3:0], ev{rst,en,upd,sw,cmp}, ref_before[5:0], ref_after[5:0], exp{pri,sec}}
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {3'd0, 4'd0,  5'b10000, 6'b000000, 6'b000000, 2'b11}, // R3 reset pulse
    {3'd1, 4'd1,  5'b01000, 6'b000000, 6'b000000, 2'b11}, // R3 enable high
    {3'd1, 4'd0,  5'b00000, 6'b000000, 6'b000000, 2'b00}, // R3 enable low
    {3'd2, 4'd2,  5'b00100, 6'b000000, 6'b000000, 2'b11}, // R3 update
    {3'd2, 4'd3,  5'b00010, 6'b000000, 6'b000000, 2'b10}, // R3 forced update
    {3'd3, 4'd3,  5'b00001, 6'b000000, 6'b000000, 2'b11}, // R3 compare
    {3'd4, 4'd8,  5'b00000, 6'b000000, 6'b010001, 2'b11}, // R5 oc1/oc5
    {3'd5, 4'd9,  5'b00000, 6'b000000, 6'b100000, 2'b01}, // R5 oc2/oc6
    {3'd6, 4'd4,  5'b00000, 6'b000000, 6'b000100, 2'b10}, // R4 oc3
    {3'd7, 4'd7,  5'b00000, 6'b000000, 6'b001000, 2'b11}, // R4 oc4
    {3'd0, 4'd10, 5'b00000, 6'b000000, 6'b001000, 2'b01}, // R6 oc4 rise
    {3'd0, 4'd10, 5'b00000, 6'b001000, 6'b000000, 2'b01}, // R6 oc4 fall
    {3'd0, 4'd10, 5'b00000, 6'b001000, 6'b001000, 2'b00}, // R6 oc4 steady
    {3'd0, 4'd11, 5'b00000, 6'b100000, 6'b000000, 2'b01}, // R6 oc6 fall
    {3'd0, 4'd12, 5'b00000, 6'b000000, 6'b100000, 2'b01}, // R7 oc6 rise
    {3'd0, 4'd12, 5'b00000, 6'b100000, 6'b000000, 2'b00}, // R7 oc6 fall ignored
    {3'd0, 4'd13, 5'b00000, 6'b100000, 6'b000000, 2'b01}, // R7 oc6 fall
    {3'd0, 4'd13, 5'b00000, 6'b001000, 6'b000000, 2'b00}, // R7 oc4 fall ignored
    {3'd0, 4'd14, 5'b00000, 6'b000000, 6'b010000, 2'b01}, // R8 oc5 rise
    {3'd0, 4'd14, 5'b00000, 6'b010000, 6'b000000, 2'b00}, // R8 oc5 fall ignored
    {3'd0, 4'd15, 5'b00000, 6'b100000, 6'b000000, 2'b01}, // R8 oc6 fall
    {3'd0, 4'd15, 5'b00000, 6'b000000, 6'b100000, 2'b00}, // R8 oc6 rise ignored
    {3'd0, 4'd15, 5'b00000, 6'b000000, 6'b010000, 2'b01}, // R8 oc5 rise
    {3'd0, 4'd11, 5'b00000, 6'b000000, 6'b001000, 2'b00}  // R6 oc4 ignored by 11
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int i);
    if (i < 6)       return "R3";
    else if (i == 6 || i == 7) return "R5";
    else if (i < 10) return "R4";
    else if (i < 14 || i == 23) return "R6";
    else if (i < 18) return "R7";
    else             return "R8";
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "rdata in reset", rdata0, 32'h0);
    chk("R1", "outputs in reset", {30'h0, p0, s0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rdata after reset", rdata0, 32'h0);
    chk("R1", "outputs after reset", {30'h0, p0, s0}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      @(negedge clk);
      we = 1'b1;
      wdata = {8'h0, v[22:19], 12'h0, 1'b0, v[25:23], 4'h0};
      oc = v[13:8];
      {c_rst, c_en, upd, sw, cmp} = 5'b0;
      @(negedge clk);
      we = 1'b0; wdata = '0;
      oc = v[7:2];
      {c_rst, c_en, upd, sw, cmp} = v[18:14];
      @(negedge clk);
      chk(req_of(i), $sformatf("vec %0d primary", i), {31'h0, p0}, {31'h0, v[1]});
      chk(req_of(i), $sformatf("vec %0d secondary", i), {31'h0, s0}, {31'h0, v[0]});
      chk(req_of(i), $sformatf("vec %0d primary no-sec build", i), {31'h0, p1}, {31'h0, v[1]});
      chk("R10", $sformatf("vec %0d secondary absent", i), {31'h0, s1}, 32'h0);
      {c_rst, c_en, upd, sw, cmp} = 5'b0;
    end

    // R9: pulse lasts one cycle while reference holds
    @(negedge clk); oc = '0;
    wr({8'h0, 4'd10, 12'h0, 1'b0, 3'd0, 4'h0});
    oc = 6'b001000;
    @(negedge clk);
    chk("R9", "pulse first cycle", {31'h0, s0}, 32'h1);
    @(negedge clk);
    chk("R9", "pulse second cycle", {31'h0, s0}, 32'h0);
    @(negedge clk);
    chk("R9", "pulse third cycle", {31'h0, s0}, 32'h0);

    // R2 / R10 readback
    wr(32'hFFFF_FFFF);
    chk("R2", "readback all ones", rdata0, 32'h00F0_0070);
    chk("R10", "absent field reads zero", rdata1, 32'h0000_0070);
    @(negedge clk);
    wdata = 32'h0;
    @(negedge clk);
    chk("R2", "hold without write", rdata0, 32'h00F0_0070);
    wr(32'h0050_0030);
    chk("R2", "readback pattern", rdata0, 32'h0050_0030);
    chk("R10", "absent field pattern", rdata1, 32'h0000_0030);

    // R10: absent secondary stays low on an edge it would pulse on
    wr({8'h0, 4'd11, 12'h0, 1'b0, 3'd0, 4'h0});
    oc = 6'b100000;
    @(negedge clk);
    chk("R6", "oc6 rise code 11", {31'h0, s0}, 32'h1);
    chk("R10", "oc6 rise absent", {31'h0, s1}, 32'h0);

    // R1: asynchronous reset mid-run
    c_en = 1'b1;
    wr({8'h0, 4'd1, 12'h0, 1'b0, 3'd1, 4'h0});
    @(negedge clk);
    chk("R3", "enable both", {30'h0, p0, s0}, 32'h3);
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "async reset rdata", rdata0, 32'h0);
    chk("R1", "async reset outputs", {30'h0, p0, s0}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    c_en = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule